// File: doc/BRIEF.md
# Load/Store Byte Lane Aligner

This block joins a 64-bit register file to a byte-addressable memory port that is one doubleword wide. On a load it takes the doubleword the memory returns and picks out the bytes of a 1, 2, 4 or 8 byte access. The low address bits, the access size and a runtime byte-order select decide which bytes it takes. It then widens the result to 64 bits with sign or zero fill. On a store it moves the low-order bytes of the source register into the lanes the access covers and raises one write enable per lane.

An access whose address is not a whole multiple of its size is flagged as misaligned. Such an access writes nothing and returns nothing. All results are registered once, so every output reflects the request sampled on the previous rising clock edge.

Top module: `lsu_align_unit`

## Requirements
- R1: The size code selects the access width: code 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes and 3 is 8 bytes. An aligned store raises exactly that many bits of `byte_we`.
- R2: `misaligned` is 1 exactly when the address modulo the access width is nonzero. Only `addr[2:0]` takes part, and the upper address bits have no effect on any output.
- R3: A misaligned access drives `byte_we`, `mem_wdata` and `load_data` to all zeros.
- R4: With `big_endian` = 0, byte i of the value (byte 0 least significant) sits in memory lane `addr[2:0]` + i. Lane k is bits 8k+7..8k of the memory word.
- R5: With `big_endian` = 1, the address names the most significant byte, and memory address a maps to lane 7 − a. The value therefore fills lanes 8 − off − n up to 7 − off with its least significant byte in the lowest of those lanes, where off is `addr[2:0]` and n is the width.
- R6: A 1, 2 or 4 byte load with `is_signed` = 1 copies the top bit of the loaded value into every higher bit of `load_data`.
- R7: A 1, 2 or 4 byte load with `is_signed` = 0 fills every higher bit of `load_data` with zeros.
- R8: An aligned 8-byte load returns the memory word unchanged in either byte order, and `is_signed` has no effect on it.
- R9: A store writes only the low-order n bytes of `store_data`. Lanes whose `byte_we` bit is 0 carry zero in `mem_wdata`.
- R10: A load (`is_store` = 0) raises no bit of `byte_we` and drives `mem_wdata` to zero. A store drives `load_data` to zero.
- R11: Every output takes the value for the inputs sampled at the previous rising edge of `clk`. While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 64 | Byte address of the access |
| size | input | 2 | Access width code (0:1, 1:2, 2:4, 3:8 bytes) |
| is_signed | input | 1 | Sign-extend loads narrower than 8 bytes |
| is_store | input | 1 | 1 for a store, 0 for a load |
| big_endian | input | 1 | Byte order select, 1 for most-significant-byte-first |
| store_data | input | 64 | Source register value for stores |
| mem_rdata | input | 64 | Doubleword returned by memory |
| load_data | output | 64 | Extended load result |
| mem_wdata | output | 64 | Lane-placed store data |
| byte_we | output | 8 | Per-lane write enables |
| misaligned | output | 1 | Address not a multiple of the access width |

## Verification
The bench goes after the lane arithmetic at both byte orders and at every offset. A mirrored-lane error would place a big-endian halfword in lanes 2–3 instead of 4–5, or reverse its bytes. A wrong alignment mask would flag odd-offset words as aligned and let their write enables through. Extension is checked where the top bit of the loaded field is set and clear. An inverted signed control, or a sign taken from the wrong bit, would show up as stray ones or stray zeros above the field. Doubleword loads are checked with the signed control set to catch a design that extends when it must not.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;

    // Access width codes; width in bytes is 1 << code.
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DBL  = 2'd3
    } acc_size_e;

endpackage

// File: rtl/lsu_lane_calc.sv
// Works out alignment, the lowest lane a value occupies and the lane mask.
module lsu_lane_calc #(
    parameter int BYTES = 8,
    localparam int OFF_W = $clog2(BYTES),
    localparam int SZ_W  = $clog2(OFF_W + 1)
) (
    input  logic [OFF_W-1:0] offset,
    input  logic [SZ_W-1:0]  size,
    input  logic             big_endian,
    output logic             aligned,
    output logic [OFF_W-1:0] base_lane,
    output logic [BYTES-1:0] lane_mask
);

    logic [OFF_W:0]   nbytes;
    logic [OFF_W-1:0] low_mask;

    always_comb begin
        nbytes   = (OFF_W+1)'(1) << size;
        low_mask = OFF_W'(nbytes - (OFF_W+1)'(1));
        aligned  = (offset & low_mask) == '0;
        // Mirrored lanes: the value ends at lane BYTES-1-offset.
        if (big_endian) begin
            base_lane = OFF_W'((OFF_W+1)'(BYTES) - nbytes - {1'b0, offset});
        end else begin
            base_lane = offset;
        end
        for (int i = 0; i < BYTES; i++) begin
            lane_mask[i] = (i >= int'(base_lane)) &&
                           (i <  int'(base_lane) + int'(nbytes));
        end
    end

endmodule

// File: rtl/lsu_load_extract.sv
// Shifts the addressed lanes down and widens them for each access width.
module lsu_load_extract #(
    parameter int DATA_W = 64,
    localparam int BYTES = DATA_W / 8,
    localparam int OFF_W = $clog2(BYTES),
    localparam int SZ_W  = $clog2(OFF_W + 1)
) (
    input  logic [DATA_W-1:0] rdata,
    input  logic [OFF_W-1:0]  base_lane,
    input  logic [SZ_W-1:0]   size,
    input  logic              sign_ext,
    output logic [DATA_W-1:0] value
);

    logic [DATA_W-1:0] shifted;
    logic [DATA_W-1:0] cand [OFF_W+1];

    assign shifted = rdata >> {base_lane, 3'b000};

    for (genvar k = 0; k <= OFF_W; k++) begin : g_width
        localparam int FW = 8 << k;
        if (FW >= DATA_W) begin : g_full
            assign cand[k] = shifted;
        end else begin : g_part
            logic fill_bit;
            assign fill_bit = sign_ext & shifted[FW-1];
            assign cand[k]  = {{(DATA_W-FW){fill_bit}}, shifted[FW-1:0]};
        end
    end

    always_comb begin
        value = '0;
        for (int k = 0; k <= OFF_W; k++) begin
            if (size == SZ_W'(k)) value = cand[k];
        end
    end

endmodule

// File: rtl/lsu_store_place.sv
// Moves the low-order source bytes up to the target lanes; other lanes zero.
module lsu_store_place #(
    parameter int DATA_W = 64,
    localparam int BYTES = DATA_W / 8,
    localparam int OFF_W = $clog2(BYTES)
) (
    input  logic [DATA_W-1:0] src,
    input  logic [OFF_W-1:0]  base_lane,
    input  logic [BYTES-1:0]  lane_mask,
    output logic [DATA_W-1:0] placed
);

    logic [DATA_W-1:0] shifted;

    assign shifted = src << {base_lane, 3'b000};

    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        assign placed[8*b +: 8] = lane_mask[b] ? shifted[8*b +: 8] : 8'h00;
    end

endmodule

// File: rtl/lsu_align_unit.sv
module lsu_align_unit #(
    parameter int ADDR_W = 64,
    parameter int DATA_W = 64,
    localparam int BYTES = DATA_W / 8,
    localparam int OFF_W = $clog2(BYTES),
    localparam int SZ_W  = $clog2(OFF_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [SZ_W-1:0]   size,
    input  logic              is_signed,
    input  logic              is_store,
    input  logic              big_endian,
    input  logic [DATA_W-1:0] store_data,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] load_data,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [BYTES-1:0]  byte_we,
    output logic              misaligned
);

    typedef struct packed {
        logic [DATA_W-1:0] ld;
        logic [DATA_W-1:0] wd;
        logic [BYTES-1:0]  we;
        logic              mis;
    } result_t;

    result_t r_d, r_q;

    logic              aligned;
    logic [OFF_W-1:0]  base_lane;
    logic [BYTES-1:0]  lane_mask;
    logic [DATA_W-1:0] ext_value;
    logic [DATA_W-1:0] placed;
    logic              unused_addr_hi;

    assign unused_addr_hi = ^addr[ADDR_W-1:OFF_W];

    lsu_lane_calc #(.BYTES(BYTES)) u_lane (
        .offset     (addr[OFF_W-1:0]),
        .size       (size),
        .big_endian (big_endian),
        .aligned    (aligned),
        .base_lane  (base_lane),
        .lane_mask  (lane_mask)
    );

    lsu_load_extract #(.DATA_W(DATA_W)) u_load (
        .rdata     (mem_rdata),
        .base_lane (base_lane),
        .size      (size),
        .sign_ext  (is_signed),
        .value     (ext_value)
    );

    lsu_store_place #(.DATA_W(DATA_W)) u_store (
        .src       (store_data),
        .base_lane (base_lane),
        .lane_mask (lane_mask),
        .placed    (placed)
    );

    always_comb begin
        r_d     = '0;
        r_d.mis = ~aligned;
        if (aligned) begin
            if (is_store) begin
                r_d.we = lane_mask;
                r_d.wd = placed;
            end else begin
                r_d.ld = ext_value;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign load_data  = r_q.ld;
    assign mem_wdata  = r_q.wd;
    assign byte_we    = r_q.we;
    assign misaligned = r_q.mis;

endmodule

// File: rtl/lsu_align_chk.sv
module lsu_align_chk
    import lsu_align_pkg::*;
#(
    parameter int DATA_W = 64,
    localparam int BYTES = DATA_W / 8,
    localparam int OFF_W = $clog2(BYTES),
    localparam int SZ_W  = $clog2(OFF_W + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [SZ_W-1:0]   size,
    input logic              is_signed,
    input logic              is_store,
    input logic [DATA_W-1:0] mem_rdata,
    input logic [DATA_W-1:0] load_data,
    input logic [DATA_W-1:0] mem_wdata,
    input logic [BYTES-1:0]  byte_we,
    input logic              misaligned
);

    // Set once a full cycle out of reset has been sampled.
    logic armed_q;
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    // R3
    misalign_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        misaligned |-> (byte_we == '0 && mem_wdata == '0 && load_data == '0));

    // R1
    we_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && byte_we != '0) |-> ($countones(byte_we) == (1 << $past(size))));

    // R10
    load_no_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !$past(is_store)) |-> (byte_we == '0 && mem_wdata == '0));

    // R8
    dbl_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(size) == SZ_DBL && !$past(is_store) && !misaligned)
        |-> (load_data == $past(mem_rdata)));

    // R6
    byte_sign_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(size) == SZ_BYTE && $past(is_signed) && !$past(is_store))
        |-> (load_data[DATA_W-1:8] == {(DATA_W-8){load_data[7]}}));

    // R7
    byte_zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(size) == SZ_BYTE && !$past(is_signed) && !$past(is_store))
        |-> (load_data[DATA_W-1:8] == '0));

endmodule

bind lsu_align_unit lsu_align_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .size       (size),
    .is_signed  (is_signed),
    .is_store   (is_store),
    .mem_rdata  (mem_rdata),
    .load_data  (load_data),
    .mem_wdata  (mem_wdata),
    .byte_we    (byte_we),
    .misaligned (misaligned)
);

// File: tb/lsu_align_unit_tb.sv
`timescale 1ns/1ps
module lsu_align_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] addr = '0;
    logic [1:0]  size = '0;
    logic        is_signed = 1'b0;
    logic        is_store = 1'b0;
    logic        big_endian = 1'b0;
    logic [63:0] store_data = '0;
    logic [63:0] mem_rdata = '0;
    logic [63:0] load_data;
    logic [63:0] mem_wdata;
    logic [7:0]  byte_we;
    logic        misaligned;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    lsu_align_unit u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .size(size),
        .is_signed(is_signed), .is_store(is_store), .big_endian(big_endian),
        .store_data(store_data), .mem_rdata(mem_rdata),
        .load_data(load_data), .mem_wdata(mem_wdata),
        .byte_we(byte_we), .misaligned(misaligned)
    );

    // Behavioural model: memory seen as bytes by address, value built byte by byte.
    task automatic model(input logic [63:0] a, input logic [1:0] sz,
                         input logic sg, input logic st, input logic be,
                         input logic [63:0] sd, input logic [63:0] rd,
                         output logic [63:0] eld, output logic [63:0] ewd,
                         output logic [7:0] ewe, output logic emis);
        int n;
        int off;
        n = 1 << sz;
        off = int'(a[2:0]);
        eld = '0; ewd = '0; ewe = '0;
        emis = (off % n) != 0;
        if (emis) return;
        for (int i = 0; i < n; i++) begin
            int adr;
            int lane;
            adr  = be ? off + n - 1 - i : off + i;
            lane = be ? 7 - adr : adr;
            if (st) begin
                ewe[lane] = 1'b1;
                ewd[8*lane +: 8] = sd[8*i +: 8];
            end else begin
                eld[8*i +: 8] = rd[8*lane +: 8];
            end
        end
        if (!st && sg && n < 8 && eld[8*n-1]) begin
            for (int j = n; j < 8; j++) eld[8*j +: 8] = 8'hFF;
        end
    endtask

    task automatic compare(input string tag, input logic [63:0] eld,
                           input logic [63:0] ewd, input logic [7:0] ewe,
                           input logic emis);
        checks++;
        if (load_data !== eld || mem_wdata !== ewd || byte_we !== ewe || misaligned !== emis) begin
            failures++;
            $display("FAIL %s: got ld=%h wd=%h we=%b mis=%b expected ld=%h wd=%h we=%b mis=%b",
                     tag, load_data, mem_wdata, byte_we, misaligned, eld, ewd, ewe, emis);
        end
    endtask

    // Drive one request at a falling edge, check it at the next falling edge.
    task automatic run_op(input string tag, input logic [63:0] a, input logic [1:0] sz,
                          input logic sg, input logic st, input logic be,
                          input logic [63:0] sd, input logic [63:0] rd);
        logic [63:0] eld, ewd;
        logic [7:0]  ewe;
        logic        emis;
        addr = a; size = sz; is_signed = sg; is_store = st;
        big_endian = be; store_data = sd; mem_rdata = rd;
        model(a, sz, sg, st, be, sd, rd, eld, ewd, ewe, emis);
        @(negedge clk);
        compare(tag, eld, ewd, ewe, emis);
    endtask

    initial begin
        #(5.0 * 200000);
        failures++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    localparam logic [63:0] RD = 64'h8877_6655_F433_2291;
    localparam logic [63:0] SD = 64'hA1B2_C3D4_E5F6_0718;

    initial begin
        // R11 reset state, with requests applied during reset
        addr = 64'h3; size = 2'd0; store_data = SD; is_store = 1'b1;
        repeat (3) @(negedge clk);
        compare("R11 reset clears outputs", '0, '0, '0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        is_store = 1'b0;

        // R4 little-endian loads
        run_op("R4 LE byte lane 5 unsigned", 64'h1005, 2'd0, 0, 0, 0, SD, RD);
        run_op("R4 LE half at 2",            64'h2,    2'd1, 0, 0, 0, SD, RD);
        // R5 big-endian loads
        run_op("R5 BE half at 2 mirrored",   64'h2,    2'd1, 0, 0, 1, SD, RD);
        run_op("R5 BE word at 4",            64'h4,    2'd2, 0, 0, 1, SD, RD);
        run_op("R5 BE byte at 0 is lane 7",  64'h0,    2'd0, 1, 0, 1, SD, RD);
        // R6 / R7 extension with top bit set (lane 3 = F4, lane 0 = 91)
        run_op("R6 signed word negative",    64'h0,    2'd2, 1, 0, 0, SD, RD);
        run_op("R7 unsigned word zero fill", 64'h0,    2'd2, 0, 0, 0, SD, RD);
        run_op("R6 signed half positive",    64'h6,    2'd1, 1, 0, 0, SD, 64'h7F01_0000_0000_0000);
        run_op("R7 unsigned byte top set",   64'h0,    2'd0, 0, 0, 0, SD, RD);
        // R8 doubleword, signed control ignored
        run_op("R8 LE dword signed ignored", 64'h8,    2'd3, 1, 0, 0, SD, RD);
        run_op("R8 BE dword passthrough",    64'h10,   2'd3, 1, 0, 1, SD, RD);
        // R1 / R9 stores
        run_op("R9 LE byte store lane 7",    64'h7,    2'd0, 0, 1, 0, SD, RD);
        run_op("R1 LE word store enables",   64'h4,    2'd2, 0, 1, 0, SD, RD);
        run_op("R5 BE half store at 6",      64'h6,    2'd1, 0, 1, 1, SD, RD);
        run_op("R1 dword store all lanes",   64'h0,    2'd3, 0, 1, 1, SD, RD);
        // R2 / R3 misalignment
        run_op("R3 misaligned word store",   64'h6,    2'd2, 0, 1, 0, SD, RD);
        run_op("R3 misaligned half load",    64'h1,    2'd1, 1, 0, 1, SD, RD);
        run_op("R2 misaligned dword",        64'h4,    2'd3, 0, 1, 0, SD, RD);
        run_op("R2 high address bits ignored", 64'hFFFF_0000_0000_000C, 2'd2, 0, 1, 1, SD, RD);
        // R10 load vs store output exclusivity
        run_op("R10 load raises no enable",  64'h0,    2'd3, 0, 0, 0, SD, RD);
        run_op("R10 store gives zero load",  64'h2,    2'd1, 1, 1, 0, SD, RD);

        // Cycle-by-cycle comparison against the model on random traffic
        for (int t = 0; t < 3000; t++) begin
            logic [63:0] a, sd, rd;
            logic [1:0]  sz;
            logic        sg, st, be;
            string       tag;
            a  = {$urandom, $urandom};
            sz = 2'($urandom);
            sg = 1'($urandom);
            st = 1'($urandom);
            be = 1'($urandom);
            sd = {$urandom, $urandom};
            rd = {$urandom, $urandom};
            if ((int'(a[2:0]) % (1 << sz)) != 0) tag = "R3 random misaligned";
            else if (st)                         tag = "R9 random store";
            else if (be)                         tag = "R5 random BE load";
            else                                 tag = "R4 random LE load";
            run_op(tag, a, sz, sg, st, be, sd, rd);
        end

        // R11 reset again mid-stream clears outputs
        rst_n = 1'b0;
        @(negedge clk);
        compare("R11 reset after traffic", '0, '0, '0, 1'b0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule